// File: doc/BRIEF.md
# Chained Prefix Hash Table Search Engine

This block settles lookups that an on-chip membership filter could not decide. When the filter reports several candidate ports for a prefix, the lookup controller hands the prefix to this engine. The engine searches a shared hash table, held in a single-port RAM, for an exact entry. Each request carries a requester tag, the prefix value, the prefix length and two precomputed hash indexes. Requests wait in an in-order queue. Two controllers can push into the queue in the same cycle.

The request at the head of the queue is served by up to three probes. The first probe reads the slot at the first hash index. The second reads the slot at the second hash index. The third follows the overflow link stored in the second slot. The search stops at the first slot whose stored prefix and length both equal the request. The engine answers with found plus the stored port, or with not-found so the controller can retry at a shorter length. The request leaves the queue only when its search has finished. A write port fills the table. Hash computation is done elsewhere.

Top module: `pfx_chain_search`

## Requirements
- R1: After reset, `rsp_vld`, `rsp_found` and `q_full` are 0.
- R2: A hit in the slot at the first hash index answers found with that slot's port. `rsp_vld` rises 2 clock edges after the edge that accepts the push into an empty, idle engine.
- R3: A miss at the first index followed by a hit at the second index answers found with the second slot's port, with `rsp_vld` 4 edges after the push.
- R4: A miss at both indexes, followed by a hit in the slot named by the second slot's link field, answers found with that slot's port, with `rsp_vld` 6 edges after the push.
- R5: A link field of all ones means the chain has no overflow slot. A miss at both indexes then skips the third probe and answers not-found with port 0, 4 edges after the push.
- R6: When none of the three probed slots matches, the engine answers not-found with port 0, 6 edges after the push.
- R7: A slot matches only if both its 32-bit prefix and its 5-bit length equal the request. The same prefix with another length does not match.
- R8: The search stops at the first matching probe in the order first index, second index, link. A later slot with the same key is never reported.
- R9: Responses carry the request's tag and come out in strict arrival order. When both requesters push in the same cycle, requester 0 is queued ahead of requester 1. A request is removed only in the cycle its search ends, and its response follows one cycle later.
- R10: `q_full` is 1 whenever fewer than two queue slots are free. Pushes offered while `q_full` is 1 are dropped and never produce a response.
- R11: A write on the table port takes effect for probes that start after it. While `tw_en` is 1 the RAM serves the write, and any pending probe read waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req0_vld | input | 1 | Requester 0 push |
| req0_tag | input | TAG_W | Requester 0 tag |
| req0_pfx | input | PFX_W | Requester 0 prefix value |
| req0_len | input | LEN_W | Requester 0 prefix length |
| req0_h1 | input | IDX_W | Requester 0 first hash index |
| req0_h2 | input | IDX_W | Requester 0 second hash index |
| req1_vld | input | 1 | Requester 1 push |
| req1_tag | input | TAG_W | Requester 1 tag |
| req1_pfx | input | PFX_W | Requester 1 prefix value |
| req1_len | input | LEN_W | Requester 1 prefix length |
| req1_h1 | input | IDX_W | Requester 1 first hash index |
| req1_h2 | input | IDX_W | Requester 1 second hash index |
| q_full | output | 1 | Fewer than two queue slots free |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | IDX_W | Table write slot |
| tw_pfx | input | PFX_W | Prefix to store |
| tw_len | input | LEN_W | Length to store |
| tw_port | input | PORT_W | Port to store |
| tw_link | input | IDX_W | Overflow link to store (all ones = none) |
| rsp_vld | output | 1 | Response strobe |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_found | output | 1 | 1 = match found |
| rsp_port | output | PORT_W | Matched port, 0 when not found |

## Verification
The bench builds the engine with NUM_PFX = 4 and QDEPTH = 4. This gives an 8-slot table with 3-bit indexes and link value 7 as the null link. With a table this small, the bench can sweep every pair of first and second hash indexes against every stored key and one absent key. Every probe path is then reached for each slot: first-index hit, second-index hit, link hit, null-link stop and full miss. The bench checks the port and the exact latency of each case. The 4-deep queue reaches full back-pressure after only two paired pushes, and the bench holds that state by keeping the write port busy.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic {
    ST_ISSUE = 1'b0,
    ST_CHECK = 1'b1
  } probe_state_e;

  typedef enum logic [1:0] {
    PR_FIRST  = 2'd0,
    PR_SECOND = 2'd1,
    PR_LINK   = 2'd2
  } probe_sel_e;
endpackage

// File: rtl/chain_req_fifo.sv
module chain_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push0,
  input  logic [W-1:0]     din0,
  input  logic             push1,
  input  logic [W-1:0]     din1,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             accept;
  logic [1:0]       n_in;

  assign full   = count > CNT_W'(DEPTH - 2);
  assign empty  = count == '0;
  assign accept = !full;
  assign n_in   = accept ? (2'(push0) + 2'(push1)) : 2'd0;
  assign head   = slots[rptr];

  always_ff @(posedge clk) begin
    if (accept && push0) slots[wptr] <= din0;
    if (accept && push1) slots[wptr + PTR_W'(push0)] <= din1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PTR_W'(n_in);
      rptr  <= rptr + PTR_W'(pop);
      count <= count + CNT_W'(n_in) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/chain_tbl_ram.sv
module chain_tbl_ram #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/chain_probe_fsm.sv
module chain_probe_fsm
  import chain_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 4,
  parameter int PFX_W  = 32,
  parameter int LEN_W  = 5,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_vld,
  input  logic [TAG_W-1:0]  h_tag,
  input  logic [PFX_W-1:0]  h_pfx,
  input  logic [LEN_W-1:0]  h_len,
  input  logic [IDX_W-1:0]  h_idx1,
  input  logic [IDX_W-1:0]  h_idx2,
  input  logic              tbl_busy,
  input  logic [PFX_W-1:0]  s_pfx,
  input  logic [LEN_W-1:0]  s_len,
  input  logic [PORT_W-1:0] s_port,
  input  logic [IDX_W-1:0]  s_link,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              pop,
  output probe_sel_e        probe_sel,
  output logic [IDX_W-1:0]  link_hold,
  output logic              rsp_vld,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_found,
  output logic [PORT_W-1:0] rsp_port
);
  function automatic logic key_equal(input logic [PFX_W-1:0] a_pfx, input logic [LEN_W-1:0] a_len,
                                     input logic [PFX_W-1:0] b_pfx, input logic [LEN_W-1:0] b_len);
    return (a_pfx == b_pfx) && (a_len == b_len);
  endfunction

  function automatic logic link_absent(input logic [IDX_W-1:0] lnk);
    return &lnk;
  endfunction

  probe_state_e state;
  logic         hit, done;

  assign rd_en = (state == ST_ISSUE) && head_vld && !tbl_busy;

  always_comb begin
    case (probe_sel)
      PR_FIRST:  rd_addr = h_idx1;
      PR_SECOND: rd_addr = h_idx2;
      default:   rd_addr = link_hold;
    endcase
  end

  assign hit  = key_equal(s_pfx, s_len, h_pfx, h_len);
  assign done = (state == ST_CHECK) &&
                (hit || (probe_sel == PR_LINK) ||
                 ((probe_sel == PR_SECOND) && link_absent(s_link)));
  assign pop  = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ISSUE;
      probe_sel <= PR_FIRST;
      link_hold <= '0;
      rsp_vld   <= 1'b0;
      rsp_tag   <= '0;
      rsp_found <= 1'b0;
      rsp_port  <= '0;
    end else begin
      rsp_vld   <= done;
      rsp_found <= done && hit;
      if (done) begin
        rsp_tag  <= h_tag;
        rsp_port <= hit ? s_port : '0;
      end
      case (state)
        ST_ISSUE: if (rd_en) state <= ST_CHECK;
        default: begin
          state <= ST_ISSUE;
          if (done) probe_sel <= PR_FIRST;
          else if (probe_sel == PR_FIRST) probe_sel <= PR_SECOND;
          else begin
            probe_sel <= PR_LINK;
            link_hold <= s_link;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pfx_chain_search.sv
module pfx_chain_search
  import chain_pkg::*;
#(
  parameter int NUM_PFX = 256,
  parameter int QDEPTH  = 4,
  parameter int TAG_W   = 4,
  parameter int PFX_W   = 32,
  parameter int LEN_W   = 5,
  parameter int PORT_W  = 3,
  localparam int NP2    = 2 ** $clog2(NUM_PFX),
  localparam int TDEPTH = 2 * NP2,
  localparam int IDX_W  = $clog2(NP2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0_vld,
  input  logic [TAG_W-1:0]  req0_tag,
  input  logic [PFX_W-1:0]  req0_pfx,
  input  logic [LEN_W-1:0]  req0_len,
  input  logic [IDX_W-1:0]  req0_h1,
  input  logic [IDX_W-1:0]  req0_h2,
  input  logic              req1_vld,
  input  logic [TAG_W-1:0]  req1_tag,
  input  logic [PFX_W-1:0]  req1_pfx,
  input  logic [LEN_W-1:0]  req1_len,
  input  logic [IDX_W-1:0]  req1_h1,
  input  logic [IDX_W-1:0]  req1_h2,
  output logic              q_full,
  input  logic              tw_en,
  input  logic [IDX_W-1:0]  tw_addr,
  input  logic [PFX_W-1:0]  tw_pfx,
  input  logic [LEN_W-1:0]  tw_len,
  input  logic [PORT_W-1:0] tw_port,
  input  logic [IDX_W-1:0]  tw_link,
  output logic              rsp_vld,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_found,
  output logic [PORT_W-1:0] rsp_port
);
  localparam int QW    = TAG_W + PFX_W + LEN_W + 2 * IDX_W;
  localparam int DW    = PFX_W + LEN_W + PORT_W + IDX_W;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  // named internal events for the bound checker
  logic              probe_rd;
  logic              pop_evt;
  logic [CNT_W-1:0]  q_count;
  probe_sel_e        probe_idx;
  logic [IDX_W-1:0]  link_reg;

  logic [QW-1:0]     head;
  logic              q_empty;
  logic [TAG_W-1:0]  h_tag;
  logic [PFX_W-1:0]  h_pfx;
  logic [LEN_W-1:0]  h_len;
  logic [IDX_W-1:0]  h_idx1, h_idx2, rd_addr;
  logic [DW-1:0]     rdata;
  logic [PFX_W-1:0]  s_pfx;
  logic [LEN_W-1:0]  s_len;
  logic [PORT_W-1:0] s_port;
  logic [IDX_W-1:0]  s_link;

  chain_req_fifo #(.DEPTH(QDEPTH), .W(QW)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push0 (req0_vld),
    .din0  ({req0_tag, req0_pfx, req0_len, req0_h1, req0_h2}),
    .push1 (req1_vld),
    .din1  ({req1_tag, req1_pfx, req1_len, req1_h1, req1_h2}),
    .pop   (pop_evt),
    .head  (head),
    .empty (q_empty),
    .full  (q_full),
    .count (q_count)
  );

  assign {h_tag, h_pfx, h_len, h_idx1, h_idx2} = head;

  chain_tbl_ram #(.DEPTH(TDEPTH), .DW(DW)) u_table (
    .clk   (clk),
    .we    (tw_en),
    .re    (probe_rd),
    .addr  (tw_en ? tw_addr : rd_addr),
    .wdata ({tw_pfx, tw_len, tw_port, tw_link}),
    .rdata (rdata)
  );

  assign {s_pfx, s_len, s_port, s_link} = rdata;

  chain_probe_fsm #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .PFX_W(PFX_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
  ) u_probe (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_vld  (!q_empty),
    .h_tag     (h_tag),
    .h_pfx     (h_pfx),
    .h_len     (h_len),
    .h_idx1    (h_idx1),
    .h_idx2    (h_idx2),
    .tbl_busy  (tw_en),
    .s_pfx     (s_pfx),
    .s_len     (s_len),
    .s_port    (s_port),
    .s_link    (s_link),
    .rd_en     (probe_rd),
    .rd_addr   (rd_addr),
    .pop       (pop_evt),
    .probe_sel (probe_idx),
    .link_hold (link_reg),
    .rsp_vld   (rsp_vld),
    .rsp_tag   (rsp_tag),
    .rsp_found (rsp_found),
    .rsp_port  (rsp_port)
  );
endmodule

// File: rtl/chain_search_chk.sv
module chain_search_chk
  import chain_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int IDX_W  = 3,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             probe_rd,
  input logic             pop_evt,
  input logic [CNT_W-1:0] q_count,
  input probe_sel_e       probe_idx,
  input logic [IDX_W-1:0] link_reg,
  input logic             q_full,
  input logic             rsp_vld
);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QDEPTH));

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !pop_evt) |=> (q_count == $past(q_count)));

  assert_rsp_after_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(pop_evt));

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> (q_count != '0));

  assert_two_cycle_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_rd |=> !probe_rd);

  assert_link_not_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_rd && probe_idx == PR_LINK) |-> !(&link_reg));
endmodule

bind pfx_chain_search chain_search_chk #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .probe_rd  (probe_rd),
  .pop_evt   (pop_evt),
  .q_count   (q_count),
  .probe_idx (probe_idx),
  .link_reg  (link_reg),
  .q_full    (q_full),
  .rsp_vld   (rsp_vld)
);

// File: tb/pfx_chain_search_test.sv
module pfx_chain_search_test;
  localparam int IW = 3;
  localparam int NSLOT = 8;
  localparam logic [IW-1:0] NULL_LNK = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req0_vld = 0, req1_vld = 0;
  logic [3:0] req0_tag = 0, req1_tag = 0;
  logic [31:0] req0_pfx = 0, req1_pfx = 0;
  logic [4:0] req0_len = 0, req1_len = 0;
  logic [IW-1:0] req0_h1 = 0, req0_h2 = 0, req1_h1 = 0, req1_h2 = 0;
  logic q_full;
  logic tw_en = 0;
  logic [IW-1:0] tw_addr = 0, tw_link = 0;
  logic [31:0] tw_pfx = 0;
  logic [4:0] tw_len = 0;
  logic [2:0] tw_port = 0;
  logic rsp_vld, rsp_found;
  logic [3:0] rsp_tag;
  logic [2:0] rsp_port;

  int nchk = 0, nfail = 0;
  logic [31:0] m_pfx [NSLOT];
  logic [4:0]  m_len [NSLOT];
  logic [2:0]  m_port [NSLOT];
  logic [IW-1:0] m_link [NSLOT];
  int got_tag [16];
  int got_port [16];
  int got_cnt;

  always #10 clk = ~clk;

  pfx_chain_search #(.NUM_PFX(4), .QDEPTH(4), .TAG_W(4)) uut (.*);

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tbl_write(input int a, input logic [31:0] p, input logic [4:0] l,
                           input logic [2:0] pt, input logic [IW-1:0] lk);
    @(negedge clk);
    tw_en = 1; tw_addr = IW'(a); tw_pfx = p; tw_len = l; tw_port = pt; tw_link = lk;
    m_pfx[a] = p; m_len[a] = l; m_port[a] = pt; m_link[a] = lk;
    @(posedge clk);
    @(negedge clk);
    tw_en = 0;
  endtask

  // expected outcome worked out from the probe order rules
  task automatic model(input logic [31:0] p, input logic [4:0] l, input int a1, input int a2,
                       output logic fnd, output int pt, output int nprobe);
    fnd = 0; pt = 0;
    nprobe = 1;
    if (m_pfx[a1] == p && m_len[a1] == l) begin fnd = 1; pt = m_port[a1]; return; end
    nprobe = 2;
    if (m_pfx[a2] == p && m_len[a2] == l) begin fnd = 1; pt = m_port[a2]; return; end
    if (m_link[a2] == NULL_LNK) return;
    nprobe = 3;
    if (m_pfx[m_link[a2]] == p && m_len[m_link[a2]] == l) begin
      fnd = 1; pt = m_port[m_link[a2]];
    end
  endtask

  task automatic single(input int tg, input logic [31:0] p, input logic [4:0] l,
                        input int a1, input int a2);
    logic efnd; int ept, enp, n;
    string rq;
    model(p, l, a1, a2, efnd, ept, enp);
    if (efnd) rq = (enp == 1) ? "R2" : (enp == 2) ? "R3" : "R4";
    else rq = (enp == 2) ? "R5" : "R6";
    @(negedge clk);
    req0_vld = 1; req0_tag = 4'(tg); req0_pfx = p; req0_len = l;
    req0_h1 = IW'(a1); req0_h2 = IW'(a2);
    @(posedge clk);
    @(negedge clk);
    req0_vld = 0;
    n = 0;
    while (!rsp_vld && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
    check(rsp_vld && rsp_found == efnd && int'(rsp_port) == ept && int'(rsp_tag) == tg,
          rq, {rsp_vld, rsp_found, rsp_port}, {1'b1, efnd, 3'(ept)});
    check(n == 2 * enp, {rq, " latency"}, n, 2 * enp);
  endtask

  task automatic collect(input int cycles);
    got_cnt = 0;
    repeat (cycles) begin
      @(posedge clk); @(negedge clk);
      if (rsp_vld && got_cnt < 16) begin
        got_tag[got_cnt] = rsp_tag;
        got_port[got_cnt] = rsp_found ? int'(rsp_port) : -1;
        got_cnt++;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(!rsp_vld && !rsp_found && !q_full, "R1", {rsp_vld, rsp_found, q_full}, 0);

    for (int i = 0; i < NSLOT; i++)
      tbl_write(i, 32'hC0A8_0000 | (i << 8), 5'(16 + i), 3'(i),
                (i % 3 == 2) ? NULL_LNK : IW'((i * 5 + 1) % 8));

    // full sweep of index pairs for stored keys and one absent key (R2..R6)
    for (int e = 0; e <= NSLOT; e++)
      for (int a1 = 0; a1 < NSLOT; a1++)
        for (int a2 = 0; a2 < NSLOT; a2++)
          if (e < NSLOT) single(e, m_pfx[e], m_len[e], a1, a2);
          else single(15, 32'hDEAD_0000, 5'd20, a1, a2);

    // R7: prefix of slot 3 with another length must miss at slot 3
    for (int a2 = 0; a2 < NSLOT; a2++) begin
      logic f; int pt, np;
      model(m_pfx[3], 5'd20, 3, a2, f, pt, np);
      check(!f, "R7 model", f, 0);
      single(7, m_pfx[3], 5'd20, 3, a2);
    end

    // R8 / R11: same key in slots 2 and 5 with different ports
    tbl_write(5, m_pfx[2], m_len[2], 3'd6, m_link[5]);
    single(8, m_pfx[2], m_len[2], 2, 5);
    check(m_port[2] == 3'd2, "R8 first index wins", m_port[2], 2);
    single(8, m_pfx[2], m_len[2], 5, 2);
    check(m_port[5] == 3'd6, "R11 write visible", m_port[5], 6);
    tbl_write(5, 32'hC0A8_0500, 5'd21, 3'd5, NULL_LNK);
    single(9, m_pfx[5], m_len[5], 5, 0);

    // R9 / R10: stall probes with a held write, then fill the queue
    @(negedge clk);
    tw_en = 1; tw_addr = 0; tw_pfx = m_pfx[0]; tw_len = m_len[0]; tw_port = m_port[0]; tw_link = m_link[0];
    req0_vld = 1; req0_tag = 1; req0_pfx = m_pfx[1]; req0_len = m_len[1]; req0_h1 = 1; req0_h2 = 0;
    req1_vld = 1; req1_tag = 2; req1_pfx = m_pfx[2]; req1_len = m_len[2]; req1_h1 = 2; req1_h2 = 0;
    @(posedge clk); @(negedge clk);
    check(!q_full, "R10 two free", q_full, 0);
    req0_tag = 3; req0_pfx = m_pfx[3]; req0_len = m_len[3]; req0_h1 = 3;
    req1_tag = 4; req1_pfx = m_pfx[4]; req1_len = m_len[4]; req1_h1 = 4;
    @(posedge clk); @(negedge clk);
    check(q_full, "R10 full", q_full, 1);
    req0_tag = 5; req0_pfx = m_pfx[5]; req0_len = m_len[5]; req0_h1 = 5;
    req1_tag = 6; req1_pfx = m_pfx[6]; req1_len = m_len[6]; req1_h1 = 6;
    @(posedge clk); @(negedge clk);
    check(!rsp_vld, "R11 probe waits for write", rsp_vld, 0);
    req0_vld = 0; req1_vld = 0; tw_en = 0;
    collect(60);
    check(got_cnt == 4, "R10 dropped pushes", got_cnt, 4);
    for (int k = 0; k < 4; k++)
      check(got_tag[k] == k + 1 && got_port[k] == k + 1, "R9 order", got_tag[k], k + 1);

    // R9: paired push without stall, then requester 1 alone
    @(negedge clk);
    req0_vld = 1; req0_tag = 10; req0_pfx = m_pfx[7]; req0_len = m_len[7]; req0_h1 = 0; req0_h2 = 7;
    req1_vld = 1; req1_tag = 11; req1_pfx = m_pfx[6]; req1_len = m_len[6]; req1_h1 = 6; req1_h2 = 0;
    @(posedge clk); @(negedge clk);
    req0_vld = 0;
    req1_tag = 12; req1_pfx = 32'h0; req1_len = 5'd1; req1_h1 = 1; req1_h2 = 2;
    @(posedge clk); @(negedge clk);
    req1_vld = 0;
    collect(40);
    check(got_cnt == 3, "R9 count", got_cnt, 3);
    check(got_tag[0] == 10 && got_port[0] == 7, "R9 req0 first", got_tag[0], 10);
    check(got_tag[1] == 11 && got_port[1] == 6, "R9 req1 second", got_tag[1], 11);
    check(got_tag[2] == 12 && got_port[2] == -1, "R5 req1 alone miss", got_port[2], -1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule